// File: doc/BRIEF.md
# UART Transmitter with Holding Register

This block serialises bytes onto an asynchronous line that idles high. The host places a byte with a one-cycle write strobe into a one-byte holding register. A shift register behind it turns each byte into a frame. The frame is one low start bit, then the data bits with the least significant first, then an optional ninth bit, then one high stop bit. Every bit lasts from one baud tick to the next. The baud tick is an input and is produced somewhere else.

The host watches `hold_empty` and writes only while that flag is high. The flag drops when a byte is written and rises again on the baud tick that moves the byte into the shifter. That transfer happens once the shifter is idle or is sending a stop bit, so frames can run back to back with no idle bit between them.

The ninth bit comes from one of two places: a software-supplied extra-bit value, or a parity bit computed from the byte. `tx_irq` rises at the beginning of each stop bit. It stays high until the host pulses `ti_clr`.

Top module: `uart_tx_hold`

## Requirements
- R1: During and straight after reset, `txd` is 1, `hold_empty` is 1 and `tx_irq` is 0.
- R2: A write strobe while `hold_empty` is 1 captures `wr_data`, and `hold_empty` reads 0 from the next cycle on.
- R3: A write strobe while `hold_empty` is 0 is dropped. The held byte is unchanged, so the next frame carries the first byte and no frame for the dropped byte follows.
- R4: On a baud tick with the holding register full and the shifter idle or sending its stop bit, the byte moves into the shifter. After that edge `hold_empty` is 1 and `txd` is 0 (start bit).
- R5: A frame is a start bit of 0, then `DATA_W` data bits with the least significant first, then the optional ninth bit, then a stop bit of 1. Each bit holds from one baud tick to the next.
- R6: A frame has a ninth bit when `xbit_en` or `par_en` is 1. With `par_en` at 0, the ninth bit equals `xbit_sw`.
- R7: With `par_en` at 1, the ninth bit comes from `par_type` and `xbit_sw` has no effect. The codes are: 00 odd (data plus bit hold an odd count of ones), 01 even, 10 constant 1, 11 constant 0.
- R8: `tx_irq` becomes 1 on the edge that starts the stop bit and stays 1 until `ti_clr`. When the set and `ti_clr` fall in the same cycle, the set wins.
- R9: With nothing held, the line stays 1 after the stop bit. When a byte is waiting, its start bit begins on the tick that ends the previous stop bit.
- R10: A write strobe in the same cycle as the tick that empties the holding register is dropped, because the register is still full in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DATA_W | Byte to send |
| xbit_en | input | 1 | Add a ninth bit to each frame |
| xbit_sw | input | 1 | Software value for the ninth bit |
| par_en | input | 1 | Ninth bit is computed parity |
| par_type | input | 2 | Parity kind: 00 odd, 01 even, 10 one, 11 zero |
| ti_clr | input | 1 | Clears the transmit interrupt flag |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can take a byte |
| tx_irq | output | 1 | Transmit interrupt flag |

## Verification
Two pairs of events can meet in one cycle. A host write can arrive on the same edge as the baud tick that empties the holding register. The flag set at stop-bit entry can arrive on the same edge as a software clear. The bench lines up the first pair by driving the strobe while the tick is high, with a byte already held. It judges the result by `hold_empty` reading 1 straight after, by the held byte going out, and by no later frame appearing. It lines up the second pair by pulsing `ti_clr` exactly in the tick cycle that starts the stop bit, and it expects `tx_irq` to still read 1 once that bit has begun.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ONE   = 2'b10,
    PAR_ZERO  = 2'b11
  } par_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } tx_state_e;

  // ones_odd is the XOR reduction of the data byte
  function automatic logic parity_bit(input logic ones_odd, input par_kind_e kind);
    logic b;
    case (kind)
      PAR_ODD:  b = ~ones_odd;
      PAR_EVEN: b = ones_odd;
      PAR_ONE:  b = 1'b1;
      default:  b = 1'b0;
    endcase
    return b;
  endfunction

  function automatic logic ninth_value(input logic ones_odd, input logic par_on,
                                       input par_kind_e kind, input logic sw_bit);
    return par_on ? parity_bit(ones_odd, kind) : sw_bit;
  endfunction

  function automatic logic has_ninth(input logic xbit_on, input logic par_on);
    return xbit_on | par_on;
  endfunction

endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic              wr_accept
);

  // A write lands only into an empty register, including on a take cycle
  assign wr_accept = wr_en & ~hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (wr_accept) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && !take |=> hold_full && hold_data == $past(hold_data));

  assert_take_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_full);

endmodule

// File: rtl/utx_shift.sv
module utx_shift
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              xbit_en,
  input  logic              xbit_sw,
  input  logic              par_en,
  input  logic [1:0]        par_type,
  output logic              take,
  output logic              stop_entry,
  output logic              txd
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              nine_on_q;
  logic              nine_val_q;
  logic              txd_q;

  logic can_load;
  logic last_data;

  assign can_load   = (state_q == ST_IDLE) || (state_q == ST_STOP);
  assign take       = baud_tick & hold_full & can_load;
  assign last_data  = (state_q == ST_DATA) && (idx_q == LAST_IDX);
  assign stop_entry = baud_tick & ((last_data & ~nine_on_q) | (state_q == ST_NINTH));
  assign txd        = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      sh_q       <= '0;
      nine_on_q  <= 1'b0;
      nine_val_q <= 1'b0;
      txd_q      <= 1'b1;
    end else if (baud_tick) begin
      case (state_q)
        ST_IDLE, ST_STOP: begin
          if (hold_full) begin
            state_q    <= ST_START;
            sh_q       <= hold_data;
            nine_on_q  <= has_ninth(xbit_en, par_en);
            nine_val_q <= ninth_value(^hold_data, par_en, par_kind_e'(par_type), xbit_sw);
            txd_q      <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
            txd_q   <= 1'b1;
          end
        end
        ST_START: begin
          state_q <= ST_DATA;
          idx_q   <= '0;
          txd_q   <= sh_q[0];
        end
        ST_DATA: begin
          if (idx_q == LAST_IDX) begin
            if (nine_on_q) begin
              state_q <= ST_NINTH;
              txd_q   <= nine_val_q;
            end else begin
              state_q <= ST_STOP;
              txd_q   <= 1'b1;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            sh_q  <= sh_q >> 1;
            txd_q <= sh_q[1];
          end
        end
        ST_NINTH: begin
          state_q <= ST_STOP;
          txd_q   <= 1'b1;
        end
        default: begin
          state_q <= ST_IDLE;
          txd_q   <= 1'b1;
        end
      endcase
    end
  end

  assert_idle_line_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> txd);

  assert_start_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd);

  assert_stop_is_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> txd && state_q == ST_STOP);

  assert_line_moves_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

endmodule

// File: rtl/utx_flags.sv
module utx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_entry,
  input  logic ti_clr,
  output logic tx_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_irq <= 1'b0;
    else if (stop_entry) tx_irq <= 1'b1;
    else if (ti_clr)     tx_irq <= 1'b0;
  end

  assert_irq_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> tx_irq);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq && !ti_clr |=> tx_irq);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_irq && !stop_entry |=> !tx_irq);

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xbit_en,
  input  logic              xbit_sw,
  input  logic              par_en,
  input  logic [1:0]        par_type,
  input  logic              ti_clr,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_irq
);

  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              wr_accept;
  logic              take;
  logic              stop_entry;

  utx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full),
    .wr_accept (wr_accept)
  );

  utx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .xbit_en    (xbit_en),
    .xbit_sw    (xbit_sw),
    .par_en     (par_en),
    .par_type   (par_type),
    .take       (take),
    .stop_entry (stop_entry),
    .txd        (txd)
  );

  utx_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_entry (stop_entry),
    .ti_clr     (ti_clr),
    .tx_irq     (tx_irq)
  );

  assign hold_empty = ~hold_full;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !hold_empty);

  assert_take_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> hold_empty);

  assert_accept_only_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> hold_empty);

endmodule

// File: tb/tb_uart_tx_hold.sv
module tb_uart_tx_hold;

  localparam int TP = 6;          // clocks per bit period
  localparam int NV = 9;

  // {data[7:0], xbit_en, par_en, par_type[1:0], xbit_sw}
  localparam logic [12:0] VEC [NV] = '{
    {8'hA5, 1'b0, 1'b0, 2'b00, 1'b1},
    {8'h3C, 1'b1, 1'b0, 2'b00, 1'b1},
    {8'h3C, 1'b1, 1'b0, 2'b00, 1'b0},
    {8'h01, 1'b0, 1'b1, 2'b00, 1'b1},
    {8'h01, 1'b0, 1'b1, 2'b01, 1'b0},
    {8'hFF, 1'b1, 1'b1, 2'b00, 1'b0},
    {8'h80, 1'b0, 1'b1, 2'b10, 1'b0},
    {8'h7F, 1'b0, 1'b1, 2'b11, 1'b1},
    {8'hC3, 1'b0, 1'b1, 2'b01, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, baud_tick, wr_en, xbit_en, xbit_sw, par_en, ti_clr;
  logic [7:0] wr_data;
  logic [1:0] par_type;
  logic txd, hold_empty, tx_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_tx_hold #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .xbit_en(xbit_en), .xbit_sw(xbit_sw), .par_en(par_en),
    .par_type(par_type), .ti_clr(ti_clr), .txd(txd), .hold_empty(hold_empty),
    .tx_irq(tx_irq)
  );

  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (TP - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ninth bit from the requirement: count ones, then apply the kind
  function automatic logic exp_ninth(input logic [7:0] d, input logic pe,
                                     input logic [1:0] pt, input logic sw);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    if (!pe) return sw;
    case (pt)
      2'b00: return (ones % 2 == 0) ? 1'b1 : 1'b0;
      2'b01: return (ones % 2 == 1) ? 1'b1 : 1'b0;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_tick();
    do begin
      @(negedge clk);
      #1;
    end while (!baud_tick);
  endtask

  task automatic write_at_tick(input logic [7:0] d);
    wait_tick();
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // skip_detect: caller is already on the start-bit sample
  task automatic run_frame(input logic [7:0] d, input bit has9, input logic b9,
                           input bit skip_detect, input bit clr_at_stop, input string tag);
    if (!skip_detect) begin
      int n = 0;
      while (txd !== 1'b0 && n < 40 * TP) begin
        @(negedge clk);
        n++;
      end
      chk(txd === 1'b0, {"R5 start found ", tag}, txd, 0);
    end
    chk(txd === 1'b0, {"R5 start bit ", tag}, txd, 0);
    chk(hold_empty === 1'b1, {"R4 empty after load ", tag}, hold_empty, 1);
    for (int i = 0; i < 8; i++) begin
      repeat (TP) @(negedge clk);
      chk(txd === d[i], {"R5 data bit ", tag}, txd, d[i]);
    end
    if (has9) begin
      repeat (TP) @(negedge clk);
      chk(txd === b9, {"R6 R7 ninth bit ", tag}, txd, b9);
    end
    if (!clr_at_stop) begin
      chk(tx_irq === 1'b0, {"R8 no irq before stop ", tag}, tx_irq, 0);
      repeat (TP) @(negedge clk);
    end else begin
      repeat (TP - 1) @(negedge clk);
      ti_clr = 1'b1;
      @(negedge clk);
      ti_clr = 1'b0;
    end
    chk(txd === 1'b1, {"R5 stop bit ", tag}, txd, 1);
    chk(tx_irq === 1'b1, {"R8 irq at stop start ", tag}, tx_irq, 1);
    ti_clr = 1'b1;
    @(negedge clk);
    ti_clr = 1'b0;
    chk(tx_irq === 1'b0, {"R8 irq cleared ", tag}, tx_irq, 0);
  endtask

  task automatic check_quiet(input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < 12 * TP; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
    end
    chk(ok && hold_empty === 1'b1, {"R9 line idle ", tag}, txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; xbit_en = 1'b0; xbit_sw = 1'b0;
    par_en = 1'b0; par_type = 2'b00; ti_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && hold_empty === 1'b1 && tx_irq === 1'b0, "R1 in reset",
        {txd, hold_empty, tx_irq}, 3'b110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd === 1'b1 && hold_empty === 1'b1 && tx_irq === 1'b0, "R1 after reset",
        {txd, hold_empty, tx_irq}, 3'b110);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      d = VEC[v][12:5];
      xbit_en = VEC[v][4];
      par_en = VEC[v][3];
      par_type = VEC[v][2:1];
      xbit_sw = VEC[v][0];
      write_at_tick(d);
      chk(hold_empty === 1'b0, "R2 write fills holding", hold_empty, 0);
      run_frame(d, VEC[v][4] | VEC[v][3], exp_ninth(d, VEC[v][3], VEC[v][2:1], VEC[v][0]),
                1'b0, 1'b0, "table");
    end

    xbit_en = 1'b0; par_en = 1'b0;

    // R3: second write while full is dropped
    write_at_tick(8'h96);
    wr_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    chk(hold_empty === 1'b0, "R3 still full", hold_empty, 0);
    run_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, "R3 held byte");
    check_quiet("R3 no dropped frame");

    // R9: back-to-back frames
    write_at_tick(8'h4E);
    fork
      run_frame(8'h4E, 1'b0, 1'b0, 1'b0, 1'b0, "R9 first");
      begin
        do @(negedge clk); while (!hold_empty);
        wr_en = 1'b1; wr_data = 8'hB1;
        @(negedge clk);
        wr_en = 1'b0;
      end
    join
    repeat (TP - 2) @(negedge clk);
    chk(txd === 1'b1, "R9 stop lasts one period", txd, 1);
    @(negedge clk);
    chk(txd === 1'b0, "R9 next start on stop end", txd, 0);
    run_frame(8'hB1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 second");
    check_quiet("R9 after pair");

    // R10: write on the load tick is dropped
    write_at_tick(8'h2D);
    wait_tick();
    wr_en = 1'b1; wr_data = 8'hE7;
    @(negedge clk);
    wr_en = 1'b0;
    chk(hold_empty === 1'b1, "R10 write on load dropped", hold_empty, 1);
    run_frame(8'h2D, 1'b0, 1'b0, 1'b1, 1'b0, "R10 held byte");
    check_quiet("R10 no extra frame");

    // R8: set and clear in the same cycle, set wins; flag sticky in between
    xbit_en = 1'b1; xbit_sw = 1'b1;
    write_at_tick(8'h0F);
    run_frame(8'h0F, 1'b1, 1'b1, 1'b0, 1'b0, "R8 first");
    write_at_tick(8'hF0);
    ti_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_irq === 1'b0, "R8 stays clear", tx_irq, 0);
    run_frame(8'hF0, 1'b1, 1'b1, 1'b0, 1'b1, "R8 set beats clear");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule